// File: doc/BRIEF.md
# Interrupt Entry Microsequencer

This block performs the hardware side of taking an interrupt in a small 8-bit processor. The surrounding core raises `insn_done` for one cycle whenever an instruction retires. In that cycle the block looks at the request line. If a request is present and the enable bit of the status word is set, it latches the 3-bit number of the requesting device. It then runs a fixed five-step entry sequence of its own, one clock per step. The sequence saves the program counter and the status word on a stack that grows downward. It then reloads both registers from a two-byte vector chosen by the device number.

The block owns the stack pointer, program counter and status word, and it drives a single memory port. The port assumes memory with a one-cycle write and a read that returns in the same cycle. While the block is idle, the core can overwrite the three registers through a write port. Each device `d` has its new PC at byte `VEC_BASE + 2*d` and its new status word at byte `VEC_BASE + 2*d + 1`, with `VEC_BASE` = 0xF0 by default. Vector status words normally hold the enable bit clear, so a handler cannot be entered again before it runs.

The control is a state machine with six states: `ST_IDLE`, `ST_DEC_SP`, `ST_PUSH_PC`, `ST_PUSH_PS`, `ST_LOAD_PC` and `ST_LOAD_PS`.
- `ST_IDLE` goes to `ST_DEC_SP` on an accepted request. Otherwise it stays in `ST_IDLE`.
- The remaining states always advance in the order listed above.
- `ST_LOAD_PS` returns to `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `mem_we` and `mem_re` are low, and `sp`, `pc` and `ps` equal their reset parameters (all zero by default).
- R2: A request is accepted at a clock edge only when the block is idle and `insn_done`, `irq` and `ps[IE_BIT]` are all high (IE_BIT = 7 by default). `busy` rises in the next cycle.
- R3: With `ps[IE_BIT]` low, a request at an instruction boundary is not taken. No memory access occurs and `sp`, `pc` and `ps` keep their values.
- R4: `irq` without `insn_done`, or `insn_done` without `irq`, starts nothing.
- R5: After acceptance the five states run in order, one cycle each, and `busy` is high for exactly those five cycles. The first state makes no memory access. Write and read are never asserted together.
- R6: The block makes exactly two writes. The old PC goes to address SP0-1 in `ST_PUSH_PC`, then the old status word goes to SP0-2 in `ST_PUSH_PS`, where SP0 is `sp` at acceptance. Each write address equals the current `sp`.
- R7: `ST_LOAD_PC` reads address `VEC_BASE + 2*R` into `pc`, and `ST_LOAD_PS` reads `VEC_BASE + 2*R + 1` into `ps`, where R is the device number.
- R8: `sp` drops by one at the end of `ST_DEC_SP` and again at the end of `ST_PUSH_PC`. It ends at SP0-2 modulo 256, so it wraps below zero.
- R9: `done` is high for exactly one cycle, the cycle that follows `ST_LOAD_PS`.
- R10: While busy, `insn_done`, `irq` and the register write port have no effect on the sequence or on the registers.
- R11: When idle and not accepting a request, `arch_we` loads `arch_sp`, `arch_pc` and `arch_ps` at the next edge.
- R12: The device number is captured at acceptance. Later changes of `irq_dev` do not change the vector read.
- R13: If the loaded status word has the enable bit set, a request at the next instruction boundary is accepted straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| irq | input | 1 | Interrupt request level |
| irq_dev | input | 3 | Number of the requesting device |
| arch_we | input | 1 | Core write strobe for SP, PC and PS |
| arch_sp | input | 8 | SP value written by the core |
| arch_pc | input | 8 | PC value written by the core |
| arch_ps | input | 8 | Status word written by the core |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| sp | output | 8 | Stack pointer |
| pc | output | 8 | Program counter |
| ps | output | 8 | Processor status word |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse after the last phase |

## Verification
The bench drives a stack pointer of 1 and of 0 to reach the modulo-256 wrap. A design that saturated or widened the stack pointer would write the status word to the wrong byte and end with a wrong `sp`. Device 7 and device 0 cover both ends of the vector table. An off-by-one or a missing doubling in the vector address would load the wrong PC or status word. The bench also holds `irq`, `insn_done`, a changed device number and register writes active for the whole sequence. A design that restarted, relatched the device or let the core write through would then corrupt the stack, the vector or the final registers. Finally, a vector status word with the enable bit set checks that re-entry is allowed immediately. A design that masked requests on its own would miss that entry.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEC_SP,
        ST_PUSH_PC,
        ST_PUSH_PS,
        ST_LOAD_PC,
        ST_LOAD_PS
    } seq_state_t;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output seq_state_t state,
    output logic       done
);
    seq_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (start) state_nxt = ST_DEC_SP;
            ST_DEC_SP:  state_nxt = ST_PUSH_PC;
            ST_PUSH_PC: state_nxt = ST_PUSH_PS;
            ST_PUSH_PS: state_nxt = ST_LOAD_PC;
            ST_LOAD_PC: state_nxt = ST_LOAD_PS;
            ST_LOAD_PS: state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // completion pulse: high in the cycle after the last phase
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_LOAD_PS);
    end
endmodule

// File: rtl/irq_seq_vec.sv
module irq_seq_vec #(
    parameter int ADDR_W = 8,
    parameter int DEV_W = 3,
    parameter logic [ADDR_W-1:0] VEC_BASE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DEV_W-1:0]  irq_dev,
    input  logic              sel_ps,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int OFS_W = DEV_W + 1;

    logic [DEV_W-1:0] dev_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     dev_q <= '0;
        else if (start) dev_q <= irq_dev;
    end

    // each device owns a byte pair: even byte PC, odd byte PS
    logic [OFS_W-1:0] ofs;
    assign ofs      = {dev_q, sel_ps};
    assign vec_addr = VEC_BASE + ADDR_W'(ofs);
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SP_RST = '0,
    parameter logic [DATA_W-1:0] PC_RST = '0,
    parameter logic [DATA_W-1:0] PS_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              start,
    input  logic              arch_we,
    input  logic [DATA_W-1:0] arch_sp,
    input  logic [DATA_W-1:0] arch_pc,
    input  logic [DATA_W-1:0] arch_ps,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ps
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RST;
            pc <= PC_RST;
            ps <= PS_RST;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (arch_we && !start) begin
                        sp <= arch_sp;
                        pc <= arch_pc;
                        ps <= arch_ps;
                    end
                end
                ST_DEC_SP, ST_PUSH_PC: sp <= sp - 1'b1;
                ST_LOAD_PC:            pc <= mem_rdata;
                ST_LOAD_PS:            ps <= mem_rdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEV_W = 3,
    parameter int IE_BIT = 7,
    parameter logic [DATA_W-1:0] VEC_BASE = 8'hF0,
    parameter logic [DATA_W-1:0] SP_RST = '0,
    parameter logic [DATA_W-1:0] PC_RST = '0,
    parameter logic [DATA_W-1:0] PS_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              irq,
    input  logic [DEV_W-1:0]  irq_dev,
    input  logic              arch_we,
    input  logic [DATA_W-1:0] arch_sp,
    input  logic [DATA_W-1:0] arch_pc,
    input  logic [DATA_W-1:0] arch_ps,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ps,
    output logic              busy,
    output logic              done
);
    seq_state_t        state;
    logic              start;
    logic [DATA_W-1:0] vec_addr;

    assign start = (state == ST_IDLE) && insn_done && irq && ps[IE_BIT];
    assign busy  = (state != ST_IDLE);

    irq_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .done  (done)
    );

    irq_seq_vec #(
        .ADDR_W   (DATA_W),
        .DEV_W    (DEV_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .irq_dev  (irq_dev),
        .sel_ps   (state == ST_LOAD_PS),
        .vec_addr (vec_addr)
    );

    irq_seq_regs #(
        .DATA_W (DATA_W),
        .SP_RST (SP_RST),
        .PC_RST (PC_RST),
        .PS_RST (PS_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .start     (start),
        .arch_we   (arch_we),
        .arch_sp   (arch_sp),
        .arch_pc   (arch_pc),
        .arch_ps   (arch_ps),
        .mem_rdata (mem_rdata),
        .sp        (sp),
        .pc        (pc),
        .ps        (ps)
    );

    // memory port, decoded from the current phase
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        mem_re    = 1'b0;
        unique case (state)
            ST_PUSH_PC: begin
                mem_addr  = sp;
                mem_we    = 1'b1;
                mem_wdata = pc;
            end
            ST_PUSH_PS: begin
                mem_addr  = sp;
                mem_we    = 1'b1;
                mem_wdata = ps;
            end
            ST_LOAD_PC, ST_LOAD_PS: begin
                mem_addr = vec_addr;
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IE_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_t        state,
    input logic              insn_done,
    input logic              irq,
    input logic [DATA_W-1:0] ps,
    input logic [DATA_W-1:0] sp,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              busy,
    input logic              done
);
    assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && insn_done && irq && ps[IE_BIT]) |=> (state == ST_DEC_SP));

    assert_no_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(insn_done && irq && ps[IE_BIT])) |=> (state == ST_IDLE));

    assert_port_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_push_at_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp));

    assert_vec_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_addr[0] == (state == ST_LOAD_PS)));

    assert_sp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC_SP || state == ST_PUSH_PC) |=> (sp == $past(sp) - 1'b1));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_LOAD_PS) |=> busy);
endmodule

bind irq_entry_seq irq_seq_chk #(
    .DATA_W (DATA_W),
    .IE_BIT (IE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .insn_done (insn_done),
    .irq       (irq),
    .ps        (ps),
    .sp        (sp),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VBASE = 8'hF0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done = 1'b0, irq = 1'b0, arch_we = 1'b0;
    logic [2:0] irq_dev = '0;
    logic [7:0] arch_sp = '0, arch_pc = '0, arch_ps = '0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, sp, pc, ps;
    logic       mem_we, mem_re, busy, done;

    logic [7:0] mem [256];
    logic [7:0] vt  [16];
    int n_chk = 0, n_fail = 0, wr_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq(irq), .irq_dev(irq_dev),
        .arch_we(arch_we), .arch_sp(arch_sp), .arch_pc(arch_pc), .arch_ps(arch_ps),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .sp(sp), .pc(pc), .ps(ps), .busy(busy), .done(done)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    function automatic logic [7:0] vec_addr_of(input logic [2:0] d, input bit hi);
        return VBASE + {4'd0, d, hi};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_vectors();
        for (int i = 0; i < 16; i++) mem[VBASE + 8'(i)] = vt[i];
    endtask

    task automatic arch_write(input logic [7:0] s, input logic [7:0] p, input logic [7:0] f);
        @(negedge clk);
        arch_we = 1'b1; arch_sp = s; arch_pc = p; arch_ps = f;
        @(negedge clk);
        arch_we = 1'b0;
    endtask

    // one full entry, checked phase by phase
    task automatic do_entry(input logic [7:0] sp0, input logic [7:0] pc0, input logic [7:0] ps_in,
                            input logic [2:0] d, input bit noise);
        logic [7:0] ps0;
        ps0 = ps_in | 8'h80;
        arch_write(sp0, pc0, ps0);
        wr_cnt = 0;
        insn_done = 1'b1; irq = 1'b1; irq_dev = d;
        for (int p = 1; p <= 5; p++) begin
            @(negedge clk);
            chk("R5 busy in phase", busy, 1);
            chk("R9 done early", done, 0);
            if (p == 1) chk("R5 no access in first phase", {mem_we, mem_re}, 0);
            if (p == 2) begin
                chk("R6 push PC addr", mem_addr, 8'(sp0 - 8'd1));
                chk("R6 push PC we", mem_we, 1);
            end
            if (p == 3) chk("R6 push PS addr", mem_addr, 8'(sp0 - 8'd2));
            if (p == 4) chk("R7 PC vector addr", mem_addr, vec_addr_of(d, 0));
            if (p == 5) chk("R7 PS vector addr", mem_addr, vec_addr_of(d, 1));
            if (noise) begin
                insn_done = 1'b1; irq = 1'b1; irq_dev = ~d;
                arch_we = 1'b1; arch_sp = 8'($urandom); arch_pc = 8'($urandom); arch_ps = 8'hFF;
            end else begin
                insn_done = 1'b0; irq = 1'b0;
            end
        end
        @(negedge clk);
        insn_done = 1'b0; irq = 1'b0; arch_we = 1'b0;
        chk("R9 done after last phase", done, 1);
        chk("R5 busy cleared", busy, 0);
        chk("R8 final sp", sp, 8'(sp0 - 8'd2));
        chk("R7 new pc", pc, vt[{d, 1'b0}]);
        chk("R7 new ps", ps, vt[{d, 1'b1}]);
        chk("R6 saved PC", mem[8'(sp0 - 8'd1)], pc0);
        chk("R6 saved PS", mem[8'(sp0 - 8'd2)], ps0);
        chk("R6 write count", wr_cnt, 2);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < 16; i++) vt[i] = (i % 2 == 1) ? (8'($urandom) & 8'h7F) : 8'($urandom);
        load_vectors();

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem strobes", {mem_we, mem_re}, 0);
        chk("R1 regs", {sp, pc, ps}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 register write port
        arch_write(8'h55, 8'hA3, 8'h12);
        chk("R11 sp", sp, 8'h55);
        chk("R11 pc", pc, 8'hA3);
        chk("R11 ps", ps, 8'h12);

        // R3 enable clear: nothing taken
        wr_cnt = 0;
        insn_done = 1'b1; irq = 1'b1; irq_dev = 3'd2;
        repeat (3) begin
            @(negedge clk);
            chk("R3 not busy", busy, 0);
        end
        insn_done = 1'b0; irq = 1'b0;
        chk("R3 regs kept", {sp, pc, ps}, {8'h55, 8'hA3, 8'h12});
        chk("R3 no writes", wr_cnt, 0);

        // R4 request without boundary and boundary without request
        arch_write(8'h60, 8'h11, 8'h80);
        irq = 1'b1; insn_done = 1'b0;
        repeat (3) begin @(negedge clk); chk("R4 irq alone", busy, 0); end
        irq = 1'b0; insn_done = 1'b1;
        repeat (3) begin @(negedge clk); chk("R4 boundary alone", busy, 0); end
        insn_done = 1'b0;

        // R2, R7 directed: both ends of the vector table
        do_entry(8'h80, 8'h3C, 8'h05, 3'd7, 0);
        do_entry(8'h40, 8'hC1, 8'h00, 3'd0, 0);

        // R8 wrap of the stack pointer
        do_entry(8'h01, 8'h77, 8'h21, 3'd0, 0);
        load_vectors();
        do_entry(8'h00, 8'h99, 8'h44, 3'd0, 0);
        load_vectors();

        // R10, R12 inputs active during the whole sequence
        do_entry(8'hA0, 8'h5A, 8'h10, 3'd5, 1);

        // R13 vector PS with enable set allows immediate re-entry
        vt[7] = vt[7] | 8'h80;
        load_vectors();
        do_entry(8'h90, 8'h20, 8'h00, 3'd3, 0);
        insn_done = 1'b1; irq = 1'b1; irq_dev = 3'd1;
        @(negedge clk);
        insn_done = 1'b0; irq = 1'b0;
        chk("R13 re-entry taken", busy, 1);
        repeat (6) @(negedge clk);
        chk("R13 second entry sp", sp, 8'h8C);
        chk("R13 second entry pc", pc, vt[2]);
        vt[7] = vt[7] & 8'h7F;
        load_vectors();

        // R2 random entries
        for (int k = 0; k < 40; k++) begin
            do_entry(8'h10 + 8'($urandom_range(0, 8'hDF)), 8'($urandom), 8'($urandom),
                     3'($urandom), bit'($urandom_range(0, 1)));
        end

        finish_run();
    end
endmodule